// File: doc/BRIEF.md
# SMM Entry/Exit Cache Flush Sequencer

This block coordinates cache flushing when a processor core enters and leaves system management mode while the protected handler memory shares its address range with ordinary memory. It takes a management interrupt request, an external flush request and the core's management-active status. Two configuration fields describe how the core caches ordinary memory (uncached, write-through or write-back) and whether the handler region is cached write-through. From the pair of settings it decides whether a flush is needed on entry, on exit, on both or on neither.

An entry flush, or any external flush, works through the same steps. In write-back mode every dirty line is first drained over a valid/ready stream. A counter loaded with the dirty-line count stands in for the write-back engine. Two acknowledge special cycles follow, and then a one-cycle done pulse. If a management interrupt was waiting, it is granted in the same cycle as the done pulse. A flush request that arrives in the same cycle as an interrupt wins, and that one flush also serves as the entry flush.

On exit the block watches the active status fall. When the sampled settings call for it, it pulses an active-low flush output for one cycle, starting at the first clock edge that sees the status low. The configuration is captured when a request is accepted and is held until the session ends.

Top module: `smm_flush_ctrl`

## Requirements
- R1: After reset `flush_n` is 1 and `wb_valid`, `spc_strobe`, `flush_done` and `smi_grant` are 0.
- R2: `cfg_smm`=1 means the handler region is write-through cached. An interrupt accepted with `cfg_smm`=1 runs a flush before it is granted, so `smi_grant` rises 3 cycles plus the drain length after acceptance. With `cfg_smm`=0 and no flush request, `smi_grant` rises in the cycle after acceptance, with no special cycles and no done pulse.
- R3: `cfg_norm` encodes ordinary memory as 0 = uncached, 1 = write-through, 2 or 3 = write-back. In write-back mode a flush with N = `dirty_lines` > 0 raises `wb_valid` for exactly N handshakes before any special cycle. `wb_line` counts N-1 down to 0, and `wb_valid` and `spc_strobe` are never high together.
- R4: Back-pressure: while `wb_valid` is high and `wb_ready` is low, `wb_valid` stays high and `wb_line` holds its value. A line retires only on a cycle where both are high.
- R5: In write-through or uncached mode, or with `dirty_lines`=0, no line is drained and the first special cycle comes in the cycle after acceptance.
- R6: Each flush issues exactly two consecutive special cycles: `spc_strobe`=1 with `spc_second`=0, then `spc_strobe`=1 with `spc_second`=1. `flush_done` is high for the single cycle after the second one.
- R7: A flush request together with an interrupt request: the flush runs first, and the grant comes in the `flush_done` cycle with no further flush. A flush with no interrupt pending ends with `flush_done` and no grant.
- R8: `smi_grant` is a one-cycle pulse.
- R9: With `cfg_norm` != 0 sampled for the session, `flush_n` goes low for exactly one cycle. It falls in the cycle that follows the first clock edge at which `smm_active` is seen low after having been high in the session.
- R10: With `cfg_norm`=0 sampled for the session, `flush_n` stays 1 on exit.
- R11: Configuration changes after acceptance do not change that session's exit decision.
- R12: A flush request that arrives during a session is held. Its flush (special cycles, no grant) starts in the second cycle after the exit pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smi_req | input | 1 | Management interrupt request, held internally until served |
| flush_req | input | 1 | External flush request, held internally until served |
| smm_active | input | 1 | Core reports management mode active |
| cfg_norm | input | 2 | Ordinary memory caching: 0 none, 1 WT, 2/3 WB |
| cfg_smm | input | 1 | Handler region cached write-through |
| dirty_lines | input | LINES_W | Dirty lines to drain, sampled when a flush starts |
| wb_ready | input | 1 | Write-back sink accepts a line |
| wb_valid | output | 1 | A dirty line is offered for write-back |
| wb_line | output | LINES_W | Index of the offered line, counting down |
| spc_strobe | output | 1 | Acknowledge special cycle in progress |
| spc_second | output | 1 | Marks the second special cycle |
| flush_done | output | 1 | One-cycle pulse after the second special cycle |
| smi_grant | output | 1 | One-cycle pulse when the interrupt is let through |
| flush_n | output | 1 | Active-low one-cycle exit flush pulse |

## Verification
Every result is registered, so it appears one clock after the edge that decides it. A grant without a flush is seen in the first cycle after acceptance. The first special cycle follows the last drain handshake by one cycle, and the done pulse and grant come two cycles after that. The exit pulse shows in the cycle after the edge that samples `smm_active` low. The bench changes inputs on falling edges and samples on the next falling edge after each rising edge, so each check reads the cycle it predicts by counting these registers. The session table records the cycle at which each event happens and compares it with the count worked out from the requirements.

// File: rtl/smm_flush_pkg.sv
package smm_flush_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_DRAIN   = 3'd1,
    ST_SPC1    = 3'd2,
    ST_SPC2    = 3'd3,
    ST_SESSION = 3'd4,
    ST_EXIT    = 3'd5
  } fsm_state_e;

  typedef struct packed {
    logic wb_mode;
    logic entry_flush;
    logic exit_flush;
  } policy_t;

  localparam logic [1:0] NORM_UNCACHED = 2'd0;

endpackage

// File: rtl/smm_flush_policy.sv
module smm_flush_policy
  import smm_flush_pkg::*;
(
  input  logic [1:0] cfg_norm,
  input  logic       cfg_smm,
  output policy_t    pol
);
  always_comb begin
    pol.wb_mode     = cfg_norm[1];
    pol.exit_flush  = (cfg_norm != NORM_UNCACHED);
    pol.entry_flush = cfg_smm;
  end
endmodule

// File: rtl/smm_wb_drain.sv
module smm_wb_drain #(
  parameter int LINES_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [LINES_W-1:0] load_val,
  input  logic               retire,
  output logic [LINES_W-1:0] cnt,
  output logic               last
);
  localparam logic [LINES_W-1:0] ONE = LINES_W'(1);

  logic [LINES_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load)    cnt_q <= load_val;
    else if (retire)  cnt_q <= cnt_q - ONE;
  end

  assign cnt  = cnt_q;
  assign last = (cnt_q == ONE);
endmodule

// File: rtl/smm_flush_fsm.sv
module smm_flush_fsm
  import smm_flush_pkg::*;
#(
  parameter int LINES_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smi_req,
  input  logic               flush_req,
  input  logic               smm_active,
  input  policy_t            live_pol,
  input  logic [LINES_W-1:0] dirty_lines,
  input  logic               wb_ready,
  input  logic [LINES_W-1:0] drain_cnt,
  input  logic               drain_last,
  output logic               drain_load,
  output logic               drain_retire,
  output logic               wb_valid,
  output logic [LINES_W-1:0] wb_line,
  output logic               spc_strobe,
  output logic               spc_second,
  output logic               flush_done,
  output logic               smi_grant,
  output logic               flush_n
);
  localparam logic [LINES_W-1:0] ONE = LINES_W'(1);

  fsm_state_e state_q, state_d;
  policy_t    pol_q, pol_d;
  logic go_smm_q, go_smm_d;
  logic seen_q, seen_d;
  logic smi_pend_q, smi_pend_d;
  logic fl_pend_q, fl_pend_d;
  logic done_q, done_d;
  logic grant_q, grant_d;
  logic fn_q, fn_d;
  logic smi_any, fl_any;
  fsm_state_e flush_start;

  assign smi_any = smi_req | smi_pend_q;
  assign fl_any  = flush_req | fl_pend_q;

  // first step of a flush: drain only in write-back mode with dirty lines
  assign flush_start = (live_pol.wb_mode && (dirty_lines != '0)) ? ST_DRAIN : ST_SPC1;

  assign wb_valid     = (state_q == ST_DRAIN);
  assign wb_line      = drain_cnt - ONE;
  assign drain_retire = wb_valid && wb_ready;

  always_comb begin
    state_d    = state_q;
    pol_d      = pol_q;
    go_smm_d   = go_smm_q;
    seen_d     = seen_q;
    smi_pend_d = smi_any;
    fl_pend_d  = fl_any;
    done_d     = 1'b0;
    grant_d    = 1'b0;
    fn_d       = 1'b1;
    drain_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fl_any) begin
          // flush wins; a waiting interrupt rides on this flush
          pol_d      = live_pol;
          go_smm_d   = smi_any;
          smi_pend_d = 1'b0;
          fl_pend_d  = 1'b0;
          drain_load = 1'b1;
          state_d    = flush_start;
        end else if (smi_any) begin
          pol_d      = live_pol;
          smi_pend_d = 1'b0;
          if (live_pol.entry_flush) begin
            go_smm_d   = 1'b1;
            drain_load = 1'b1;
            state_d    = flush_start;
          end else begin
            grant_d = 1'b1;
            seen_d  = 1'b0;
            state_d = ST_SESSION;
          end
        end
      end
      ST_DRAIN: begin
        if (drain_retire && drain_last) state_d = ST_SPC1;
      end
      ST_SPC1: state_d = ST_SPC2;
      ST_SPC2: begin
        done_d = 1'b1;
        if (go_smm_q) begin
          grant_d  = 1'b1;
          go_smm_d = 1'b0;
          seen_d   = 1'b0;
          state_d  = ST_SESSION;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_SESSION: begin
        if (smm_active) begin
          seen_d = 1'b1;
        end else if (seen_q) begin
          if (pol_q.exit_flush) begin
            fn_d    = 1'b0;
            state_d = ST_EXIT;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_EXIT: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pol_q      <= '0;
      go_smm_q   <= 1'b0;
      seen_q     <= 1'b0;
      smi_pend_q <= 1'b0;
      fl_pend_q  <= 1'b0;
      done_q     <= 1'b0;
      grant_q    <= 1'b0;
      fn_q       <= 1'b1;
    end else begin
      state_q    <= state_d;
      pol_q      <= pol_d;
      go_smm_q   <= go_smm_d;
      seen_q     <= seen_d;
      smi_pend_q <= smi_pend_d;
      fl_pend_q  <= fl_pend_d;
      done_q     <= done_d;
      grant_q    <= grant_d;
      fn_q       <= fn_d;
    end
  end

  assign spc_strobe = (state_q == ST_SPC1) || (state_q == ST_SPC2);
  assign spc_second = (state_q == ST_SPC2);
  assign flush_done = done_q;
  assign smi_grant  = grant_q;
  assign flush_n    = fn_q;
endmodule

// File: rtl/smm_flush_ctrl.sv
module smm_flush_ctrl
  import smm_flush_pkg::*;
#(
  parameter int LINES_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smi_req,
  input  logic               flush_req,
  input  logic               smm_active,
  input  logic [1:0]         cfg_norm,
  input  logic               cfg_smm,
  input  logic [LINES_W-1:0] dirty_lines,
  input  logic               wb_ready,
  output logic               wb_valid,
  output logic [LINES_W-1:0] wb_line,
  output logic               spc_strobe,
  output logic               spc_second,
  output logic               flush_done,
  output logic               smi_grant,
  output logic               flush_n
);
  policy_t            live_pol;
  logic               drain_load, drain_retire, drain_last;
  logic [LINES_W-1:0] drain_cnt;

  smm_flush_policy u_policy (
    .cfg_norm (cfg_norm),
    .cfg_smm  (cfg_smm),
    .pol      (live_pol)
  );

  smm_wb_drain #(.LINES_W(LINES_W)) u_drain (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (drain_load),
    .load_val (dirty_lines),
    .retire   (drain_retire),
    .cnt      (drain_cnt),
    .last     (drain_last)
  );

  smm_flush_fsm #(.LINES_W(LINES_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .smi_req      (smi_req),
    .flush_req    (flush_req),
    .smm_active   (smm_active),
    .live_pol     (live_pol),
    .dirty_lines  (dirty_lines),
    .wb_ready     (wb_ready),
    .drain_cnt    (drain_cnt),
    .drain_last   (drain_last),
    .drain_load   (drain_load),
    .drain_retire (drain_retire),
    .wb_valid     (wb_valid),
    .wb_line      (wb_line),
    .spc_strobe   (spc_strobe),
    .spc_second   (spc_second),
    .flush_done   (flush_done),
    .smi_grant    (smi_grant),
    .flush_n      (flush_n)
  );
endmodule

// File: rtl/smm_flush_ctrl_chk.sv
module smm_flush_ctrl_chk #(
  parameter int LINES_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               smm_active,
  input logic               wb_ready,
  input logic               wb_valid,
  input logic [LINES_W-1:0] wb_line,
  input logic               spc_strobe,
  input logic               spc_second,
  input logic               flush_done,
  input logic               smi_grant,
  input logic               flush_n
);
  assert_exit_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_n |=> flush_n);

  assert_exit_after_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_n) |-> !$past(smm_active));

  assert_spc_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spc_strobe && !spc_second) |=> (spc_strobe && spc_second));

  assert_done_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spc_strobe && spc_second) |=> flush_done);

  assert_grant_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    smi_grant |=> !smi_grant);

  assert_wb_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_line)));

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !spc_strobe);
endmodule

bind smm_flush_ctrl smm_flush_ctrl_chk #(.LINES_W(LINES_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smm_active (smm_active),
  .wb_ready   (wb_ready),
  .wb_valid   (wb_valid),
  .wb_line    (wb_line),
  .spc_strobe (spc_strobe),
  .spc_second (spc_second),
  .flush_done (flush_done),
  .smi_grant  (smi_grant),
  .flush_n    (flush_n)
);

// File: tb/smm_flush_ctrl_bench.sv
module smm_flush_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINES_W    = 8;
  localparam int NVEC       = 8;

  // vector: [15:14] cfg_norm, [13] cfg_smm, [12:8] dirty, [7] flush with smi, [6:5] cfg_norm mid-session
  localparam logic [15:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 5'd0, 1'b0, 2'd0, 5'd0},
    {2'd1, 1'b0, 5'd5, 1'b0, 2'd1, 5'd0},
    {2'd0, 1'b1, 5'd3, 1'b0, 2'd0, 5'd0},
    {2'd2, 1'b1, 5'd3, 1'b0, 2'd2, 5'd0},
    {2'd2, 1'b0, 5'd4, 1'b1, 2'd2, 5'd0},
    {2'd1, 1'b1, 5'd2, 1'b0, 2'd0, 5'd0},
    {2'd0, 1'b0, 5'd2, 1'b0, 2'd2, 5'd0},
    {2'd3, 1'b1, 5'd0, 1'b0, 2'd3, 5'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smi_req = 1'b0, flush_req = 1'b0, smm_active = 1'b0;
  logic [1:0] cfg_norm = 2'd0;
  logic cfg_smm = 1'b0;
  logic [LINES_W-1:0] dirty_lines = '0;
  logic wb_ready = 1'b1;
  logic wb_valid, spc_strobe, spc_second, flush_done, smi_grant, flush_n;
  logic [LINES_W-1:0] wb_line;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smm_flush_ctrl #(.LINES_W(LINES_W)) u_smm_flush_ctrl (
    .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .flush_req(flush_req),
    .smm_active(smm_active), .cfg_norm(cfg_norm), .cfg_smm(cfg_smm),
    .dirty_lines(dirty_lines), .wb_ready(wb_ready), .wb_valid(wb_valid),
    .wb_line(wb_line), .spc_strobe(spc_strobe), .spc_second(spc_second),
    .flush_done(flush_done), .smi_grant(smi_grant), .flush_n(flush_n)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic exit_session(input int exp_exit, input string req);
    smm_active = 1'b1;
    tick();
    tick();
    smm_active = 1'b0;
    tick();
    check(req, "flush_n on exit", int'(flush_n), exp_exit ? 0 : 1);
    tick();
    check("R9", "flush_n after pulse", int'(flush_n), 1);
  endtask

  task automatic run_session(input logic [15:0] v);
    int norm, smm, dirty, fw, mid, drain, entry, ex, exp_grant;
    int hs, spc, grant_cyc, done_cyc;
    bit line_ok, spc_ord;
    norm = int'(v[15:14]); smm = int'(v[13]); dirty = int'(v[12:8]);
    fw = int'(v[7]); mid = int'(v[6:5]);
    drain = (norm >= 2) ? dirty : 0;
    entry = (smm != 0 || fw != 0) ? 1 : 0;
    ex = (norm != 0) ? 1 : 0;
    exp_grant = entry ? drain + 3 : 1;
    cfg_norm = v[15:14]; cfg_smm = v[13]; dirty_lines = LINES_W'(dirty);
    wb_ready = 1'b1; smi_req = 1'b1; flush_req = v[7];
    hs = 0; spc = 0; grant_cyc = -1; done_cyc = -1; line_ok = 1'b1; spc_ord = 1'b1;
    for (int c = 1; c <= 60 && grant_cyc < 0; c++) begin
      tick();
      smi_req = 1'b0; flush_req = 1'b0;
      if (wb_valid) begin
        if (int'(wb_line) != dirty - 1 - hs) line_ok = 1'b0;
        hs++;
      end
      if (spc_strobe) begin
        if (int'(spc_second) != ((spc != 0) ? 1 : 0)) spc_ord = 1'b0;
        spc++;
      end
      if (flush_done && done_cyc < 0) done_cyc = c;
      if (smi_grant) grant_cyc = c;
    end
    check("R3", "drain handshakes", hs, drain);
    check("R3", "wb_line countdown ok", int'(line_ok), 1);
    check(entry ? "R2" : "R5", "special cycle count", spc, entry ? 2 : 0);
    check("R6", "special cycle order", int'(spc_ord), 1);
    check(entry ? "R2" : "R8", "grant cycle", grant_cyc, exp_grant);
    check(fw ? "R7" : "R2", "done cycle", done_cyc, entry ? grant_cyc : -1);
    tick();
    check("R8", "grant is one cycle", int'(smi_grant), 0);
    cfg_norm = 2'(mid);  // R11: late change must not matter
    exit_session(ex, ex ? "R9" : "R10");
    check("R11", "no stray special cycle", int'(spc_strobe), 0);
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "flush_n in reset", int'(flush_n), 1);
    rst_n = 1'b1;
    tick();
    check("R1", "wb_valid", int'(wb_valid), 0);
    check("R1", "spc_strobe", int'(spc_strobe), 0);
    check("R1", "flush_done", int'(flush_done), 0);
    check("R1", "smi_grant", int'(smi_grant), 0);
    check("R1", "flush_n", int'(flush_n), 1);

    for (int i = 0; i < NVEC; i++) run_session(VEC[i]);

    // R4: back-pressure during a write-back drain of 3 lines
    cfg_norm = 2'd2; cfg_smm = 1'b1; dirty_lines = LINES_W'(3);
    wb_ready = 1'b0; smi_req = 1'b1;
    tick();
    smi_req = 1'b0;
    check("R4", "valid under stall", int'(wb_valid), 1);
    check("R4", "first line", int'(wb_line), 2);
    tick();
    check("R4", "valid held", int'(wb_valid), 1);
    check("R4", "line held", int'(wb_line), 2);
    wb_ready = 1'b1;
    tick();
    check("R4", "line after retire", int'(wb_line), 1);
    tick();
    check("R4", "last line", int'(wb_line), 0);
    tick();
    check("R3", "special after drain", int'(spc_strobe && !spc_second), 1);
    tick();
    tick();
    check("R2", "grant after entry flush", int'(smi_grant), 1);
    tick();
    exit_session(1, "R9");
    tick();

    // R12: flush request inside a session is served after exit
    cfg_norm = 2'd1; cfg_smm = 1'b0; dirty_lines = LINES_W'(4);
    smi_req = 1'b1;
    tick();
    smi_req = 1'b0;
    check("R2", "direct grant", int'(smi_grant), 1);
    flush_req = 1'b1;
    tick();
    flush_req = 1'b0;
    check("R12", "no flush inside session", int'(spc_strobe), 0);
    exit_session(1, "R9");
    tick();
    check("R12", "held flush first special", int'(spc_strobe && !spc_second), 1);
    tick();
    check("R6", "second special", int'(spc_strobe && spc_second), 1);
    tick();
    check("R7", "standalone done", int'(flush_done), 1);
    check("R7", "no grant without smi", int'(smi_grant), 0);
    tick();
    check("R6", "done is one cycle", int'(flush_done), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule